// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block is a bank of thirty-two general-purpose 32-bit registers for a simple processor datapath. Two read ports each take their own 5-bit index and return the selected register at the same time. One write port takes a separate 5-bit index, a data word and an enable. Register 0 is a constant zero: it reads as zero on both ports, and writes aimed at it are dropped.

Writes are committed on the falling clock edge, and reads are combinational. A value driven onto the write port early in a cycle can therefore be read back in the second half of that same cycle. The decode stage reads operands after the edge, while the write-back stage updates the bank before it. An active-high reset, sampled on the falling edge, clears every register to zero and gives the bank a defined starting value.

The design has no state machine. Control is a single write-enable decode per entry, and the only sequencing is the edge on which data is committed.

Top module: `gpr_bank`

## Requirements
- R1: The bank holds 32 registers of 32 bits. Each register at index 1 to 31 keeps its own value, and it can be read back unchanged on either port.
- R2: Index 0 reads as 32'h0 on both read ports at all times, including after a write with enable high and write index 0.
- R3: A write is committed only on the falling clock edge. During the high phase of the cycle that carries the write, a read of the written index still returns the old value. After the falling edge of that cycle, the read returns the new value.
- R4: When the write enable is low at the falling edge, no register changes, whatever the write index and write data are.
- R5: The two read ports are independent. In the same cycle, each port returns the register selected by its own index.
- R6: The write index is separate from the read indices. A write changes only the register it addresses, and every other register reads back unchanged.
- R7: When reset is high at a falling edge, all registers are cleared to zero. Reset takes precedence over a write in the same cycle.
- R8: When both read indices are equal, both ports return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Writes and reset act on its falling edge. |
| rst | input | 1 | Active-high synchronous reset. Clears all registers. |
| rd_idx_a | input | 5 | Register index for read port A. |
| rd_idx_b | input | 5 | Register index for read port B. |
| wr_idx | input | 5 | Register index for the write port. |
| wr_data | input | 32 | Data word to write. |
| wr_en | input | 1 | Write enable, active high. |
| rd_val_a | output | 32 | Combinational read data for port A. |
| rd_val_b | output | 32 | Combinational read data for port B. |

## Verification
Two functions can fall in the same cycle, and the bench provokes both overlaps.

- **Write and read of the same index.** The bench drives a write and a read of the same index together. It samples the read ports in the high phase and expects the old contents. It samples them again just after the falling edge and expects the new word.
- **Reset and write.** The bench raises reset and a write in the same cycle. It then expects every register, including the one addressed by the write, to read as zero.

A behavioural model of the bank in the bench is updated at each falling edge. Both ports are compared against it on every cycle, before and after that edge.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    parameter int unsigned GPR_DEFAULT_COUNT = 32;
    parameter int unsigned GPR_DEFAULT_WIDTH = 32;

    // Index width needed to address a given number of entries.
    function automatic int unsigned idx_width(int unsigned entries);
        return (entries < 2) ? 1 : $clog2(entries);
    endfunction

endpackage

// File: rtl/gpr_store.sv
module gpr_store
    import gpr_pkg::*;
#(
    parameter int unsigned COUNT = GPR_DEFAULT_COUNT,
    parameter int unsigned WIDTH = GPR_DEFAULT_WIDTH,
    parameter int unsigned IW    = idx_width(COUNT)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IW-1:0]               wr_idx,
    input  logic [WIDTH-1:0]            wr_data,
    output logic [COUNT-1:0][WIDTH-1:0] bank
);

    // Entry 0 is never loaded; it keeps its cleared value.
    always_ff @(negedge clk) begin
        if (rst) begin
            bank <= '0;
        end else begin
            for (int e = 1; e < COUNT; e++) begin
                if (wr_en && (wr_idx == IW'(e))) begin
                    bank[e] <= wr_data;
                end
            end
        end
    end

    // R3: an enabled write to a nonzero index lands at the falling edge
    a_r3_commit: assert property (@(negedge clk) disable iff (rst)
        (wr_en && wr_idx != '0) |=> (bank[$past(wr_idx)] == $past(wr_data)));

    // R4: with the enable low, or the write aimed at index 0, nothing changes
    a_r4_hold: assert property (@(negedge clk) disable iff (rst)
        (!wr_en || wr_idx == '0) |=> $stable(bank));

    // R7: reset empties the whole bank
    a_r7_clear: assert property (@(negedge clk)
        rst |=> (bank == '0));

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
    import gpr_pkg::*;
#(
    parameter int unsigned COUNT = GPR_DEFAULT_COUNT,
    parameter int unsigned WIDTH = GPR_DEFAULT_WIDTH,
    parameter int unsigned IW    = idx_width(COUNT)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [COUNT-1:0][WIDTH-1:0] bank,
    input  logic [IW-1:0]               idx,
    output logic [WIDTH-1:0]            data
);

    logic [WIDTH-1:0] picked;

    always_comb begin
        picked = '0;
        for (int e = 0; e < COUNT; e++) begin
            if (idx == IW'(e)) begin
                picked = bank[e];
            end
        end
    end

    // Index 0 is forced to zero at the port, independent of the storage.
    assign data = (idx == '0) ? '0 : picked;

    // R2: a read of index 0 never returns a nonzero word
    a_r2_zero_read: assert property (@(posedge clk) disable iff (rst)
        (idx == '0) |-> (data == '0));

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_pkg::*;
#(
    parameter int unsigned COUNT = GPR_DEFAULT_COUNT,
    parameter int unsigned WIDTH = GPR_DEFAULT_WIDTH,
    localparam int unsigned IW   = idx_width(COUNT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IW-1:0]    rd_idx_a,
    input  logic [IW-1:0]    rd_idx_b,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_en,
    output logic [WIDTH-1:0] rd_val_a,
    output logic [WIDTH-1:0] rd_val_b
);

    localparam int unsigned NPORTS = 2;

    logic [COUNT-1:0][WIDTH-1:0] bank;
    logic [NPORTS-1:0][IW-1:0]   port_idx;
    logic [NPORTS-1:0][WIDTH-1:0] port_val;

    gpr_store #(.COUNT(COUNT), .WIDTH(WIDTH), .IW(IW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .bank    (bank)
    );

    assign port_idx[0] = rd_idx_a;
    assign port_idx[1] = rd_idx_b;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        gpr_read_port #(.COUNT(COUNT), .WIDTH(WIDTH), .IW(IW)) u_rd (
            .clk  (clk),
            .rst  (rst),
            .bank (bank),
            .idx  (port_idx[p]),
            .data (port_val[p])
        );
    end

    assign rd_val_a = port_val[0];
    assign rd_val_b = port_val[1];

    // R8: equal indices on the two independent ports give equal data
    a_r8_same_index: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == rd_idx_b) |-> (rd_val_a == rd_val_b));

endmodule

// File: tb/gpr_bank_test.sv
`timescale 1ns/1ps
module gpr_bank_test;

    localparam int N = 32;
    localparam int W = 32;
    localparam int LIMIT = 200000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [4:0]   rd_idx_a = '0;
    logic [4:0]   rd_idx_b = '0;
    logic [4:0]   wr_idx = '0;
    logic [W-1:0] wr_data = '0;
    logic         wr_en = 1'b0;
    logic [W-1:0] rd_val_a;
    logic [W-1:0] rd_val_b;

    int errors = 0;
    int checks = 0;
    bit armed = 1'b0;
    logic [W-1:0] model [N];

    always #2.5 clk = ~clk;

    gpr_bank uut (
        .clk      (clk),
        .rst      (rst),
        .rd_idx_a (rd_idx_a),
        .rd_idx_b (rd_idx_b),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .wr_en    (wr_en),
        .rd_val_a (rd_val_a),
        .rd_val_b (rd_val_b)
    );

    function automatic logic [W-1:0] pat(int i);
        return (32'h9E3779B9 * (i + 1)) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [W-1:0] expect_of(int i);
        return (i == 0) ? '0 : model[i];
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    // One cycle: drive after the rising edge, compare in the high phase,
    // update the model at the falling edge, compare again just after it.
    task automatic step(string tag, bit r, int ra, int rb, int wa,
                        logic [W-1:0] wd, bit we);
        @(posedge clk);
        #1;
        rst      = r;
        rd_idx_a = 5'(ra);
        rd_idx_b = 5'(rb);
        wr_idx   = 5'(wa);
        wr_data  = wd;
        wr_en    = we;
        #0.5;
        if (armed) begin
            check({tag, " R3 pre-edge port A"}, rd_val_a, expect_of(ra));
            check({tag, " R3 pre-edge port B"}, rd_val_b, expect_of(rb));
        end
        @(negedge clk);
        if (r) begin
            for (int k = 0; k < N; k++) model[k] = '0;
            armed = 1'b1;
        end else if (we && wa != 0) begin
            model[wa] = wd;
        end
        #1;
        if (armed) begin
            check({tag, " port A"}, rd_val_a, expect_of(ra));
            check({tag, " port B"}, rd_val_b, expect_of(rb));
        end
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) model[k] = '0;
        step("R7 reset", 1, 0, 1, 0, '0, 0);
        step("R7 reset", 1, 2, 3, 0, '0, 0);
        // reset state on every index
        for (int i = 0; i < N; i++) step("R7 reset state", 0, i, N - 1 - i, 0, '0, 0);
        // write index 0: must stay zero
        step("R2 write to index zero", 0, 0, 0, 0, pat(0), 1);
        // fill, reading the written index and its neighbour
        for (int i = 1; i < N; i++)
            step("R1 R6 fill", 0, i, (i + 1) % N, i, pat(i), 1);
        // independent two-port readback of everything
        for (int i = 0; i < N; i++)
            step("R1 R5 readback", 0, i, N - 1 - i, 0, '0, 0);
        // enable low: no change
        step("R4 enable low", 0, 3, 2, 3, ~pat(3), 0);
        step("R4 enable low", 0, 17, 16, 17, 32'hFFFFFFFF, 0);
        step("R4 enable low", 0, 31, 30, 31, 32'h0, 0);
        // only the addressed entry changes
        step("R6 write 20 read others", 0, 19, 21, 20, 32'h0BADF00D, 1);
        step("R6 write 20 readback", 0, 20, 19, 0, '0, 0);
        // same index on both ports
        step("R8 equal indices", 0, 9, 9, 0, '0, 0);
        step("R8 equal indices zero", 0, 0, 0, 0, '0, 0);
        step("R8 equal indices top", 0, 31, 31, 0, '0, 0);
        // write and read of one index in one cycle
        step("R3 same-cycle write", 0, 12, 12, 12, 32'hCAFEF00D, 1);
        step("R3 same-cycle write", 0, 12, 7, 12, 32'h13572468, 1);
        step("R2 zero port B", 0, 5, 0, 0, 32'hFFFFFFFF, 1);
        // reset and write in one cycle
        step("R7 reset beats write", 1, 5, 6, 5, 32'h00001234, 1);
        for (int i = 0; i < N; i++)
            step("R7 cleared", 0, i, N - 1 - i, 0, '0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule